// File: doc/BRIEF.md
# Sliding-Window Sign-Weighted Cross-Correlator

This block keeps a ROWS-by-COLS matrix of running correlations between a vector of antipodal bits and a vector of signed samples. Each bit stands for +1 or -1, so every product is simply the sample added or subtracted. One update slides a window forward by one step. It adds the contribution of the newest bit/sample pair and removes the contribution of the pair that leaves the window. Both changes go into each entry with a single write.

The entries live in an on-chip memory, not in a register array. A single read-modify-write loop visits them one per cycle in row-major order. At power-up the block first sweeps the memory to zero. A separate read port lets the consumer fetch any entry, one cycle after it presents the address. For complex samples, two copies are used, one for each component.

Top module: `xcorr_window`

## Requirements
- R1: After reset is released, the block spends exactly ROWS*COLS cycles writing zero to every entry, with busy high throughout. A start during this sweep is ignored and no done pulse appears. The same holds when reset arrives in the middle of an update.
- R2: A start seen with busy low is accepted, and the bench sees busy high in the following cycle. At acceptance the block latches bit_new, bit_old, smp_new and smp_old. Later changes to these inputs do not affect that update's result.
- R3: An update changes every entry (i,j) to its old value + s(bit_new[i])*x_new[j] - s(bit_old[i])*x_old[j]. Here s(1)=+1 and s(0)=-1. The term x_new[j] is the two's-complement SW-bit sample smp_new[j*SW +: SW], and x_old[j] is taken from smp_old the same way.
- R4: Entries are AW bits wide (16 by default) and wrap modulo 2^AW on overflow.
- R5: After an accepted start, busy stays high for ROWS*COLS+1 cycles. Then done is high for exactly one cycle, with busy low in that cycle.
- R6: A start that arrives while busy is high is ignored. The running update keeps its length and its result.
- R7: rd_data shows entry (rd_row, rd_col) one cycle after the address is presented. Entries are stored in row-major order.
- R8: A read of the entry that is being written in the same cycle returns the newly written value, not the stale one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the zeroing sweep |
| start | input | 1 | Request one window-slide update |
| bit_new | input | ROWS | Incoming bit vector, 1 = +1, 0 = -1 |
| bit_old | input | ROWS | Outgoing bit vector, same encoding |
| smp_new | input | COLS*SW | Incoming samples, column j at [j*SW +: SW] |
| smp_old | input | COLS*SW | Outgoing samples, same packing |
| rd_row | input | clog2(ROWS) | Read row index |
| rd_col | input | clog2(COLS) | Read column index |
| busy | output | 1 | Sweep or update in progress |
| done | output | 1 | One-cycle pulse after the last entry is written |
| rd_data | output | AW | Entry at the read address, one cycle late |

## Verification
The bench reads the last entry while that entry is being written back in the final cycle of an update. A design that does not forward the write would return the pre-update value there. It also scrambles the inputs and raises start in the middle of an update. Failing to latch the inputs, or letting start restart the loop, would then corrupt the matrix or stretch the busy window. About 130 identical updates push every entry past the positive limit, which exposes any saturation or any sign error in the old-pair term. A reset in the middle of an update, and a start during the zeroing sweep, check that no entry survives and that no stray done pulse appears.

// File: rtl/xcorr_window.sv
`timescale 1ns/1ps
module xcorr_window #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int SW   = 8,
  parameter int AW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROWS-1:0]    bit_new,
  input  logic [ROWS-1:0]    bit_old,
  input  logic [COLS*SW-1:0] smp_new,
  input  logic [COLS*SW-1:0] smp_old,
  input  logic [RW-1:0]      rd_row,
  input  logic [CW-1:0]      rd_col,
  output logic               busy,
  output logic               done,
  output logic [AW-1:0]      rd_data
);
  localparam int DEPTH = ROWS * COLS;
  localparam int DW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]      mem [DEPTH];
  logic               clr, run, s1_v, s1_last;
  logic [DW-1:0]      clr_a, s1_a;
  logic [RW-1:0]      row, s1_row;
  logic [CW-1:0]      col, s1_col;
  logic [ROWS-1:0]    bn_q, bo_q;
  logic [COLS*SW-1:0] rn_q, ro_q;
  logic [AW-1:0]      s1_q;

  logic               accept, last, we;
  logic [DW-1:0]      ia, ea, wa;
  logic [AW-1:0]      wd, ext_n, ext_o, tn, to;
  logic [SW-1:0]      xn, xo;

  assign busy   = clr | run | s1_v;
  assign accept = start & ~busy;
  assign last   = (row == RW'(ROWS-1)) && (col == CW'(COLS-1));
  assign ia     = DW'(row) * DW'(COLS) + DW'(col);
  assign ea     = DW'(rd_row) * DW'(COLS) + DW'(rd_col);

  assign xn    = rn_q[int'(s1_col)*SW +: SW];
  assign xo    = ro_q[int'(s1_col)*SW +: SW];
  assign ext_n = {{(AW-SW){xn[SW-1]}}, xn};
  assign ext_o = {{(AW-SW){xo[SW-1]}}, xo};
  assign tn    = bn_q[s1_row] ? ext_n : -ext_n;
  assign to    = bo_q[s1_row] ? ext_o : -ext_o;

  assign we = clr | s1_v;
  assign wa = clr ? clr_a : s1_a;
  assign wd = clr ? '0 : s1_q + tn - to;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (run) s1_q <= (we && wa == ia) ? wd : mem[ia];
    rd_data <= (we && wa == ea) ? wd : mem[ea];
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      bn_q <= bit_new;
      bo_q <= bit_old;
      rn_q <= smp_new;
      ro_q <= smp_old;
    end
    s1_row <= row;
    s1_col <= col;
    s1_a   <= ia;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr     <= 1'b1;
      clr_a   <= '0;
      run     <= 1'b0;
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      done    <= 1'b0;
      row     <= '0;
      col     <= '0;
    end else begin
      done    <= s1_v & s1_last;
      s1_v    <= run;
      s1_last <= run & last;
      if (clr) begin
        clr_a <= clr_a + 1'b1;
        if (clr_a == DW'(DEPTH-1)) clr <= 1'b0;
      end
      if (accept) begin
        run <= 1'b1;
        row <= '0;
        col <= '0;
      end else if (run) begin
        if (last) run <= 1'b0;
        if (col == CW'(COLS-1)) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xcorr_window_chk.sv
`timescale 1ns/1ps
module xcorr_window_chk #(
  parameter int DEPTH = 64
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic clr,
  input logic we
);
  logic [31:0] ucnt, ccnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt <= '0;
      ccnt <= '0;
    end else begin
      if (start && !busy) ucnt <= '0;
      else if (busy && !clr) ucnt <= ucnt + 1;
      if (clr) ccnt <= ccnt + 1;
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_update_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ucnt == 32'(DEPTH + 1));
  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_clear_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr) |-> ccnt == 32'(DEPTH));
  assert_no_idle_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !we);
endmodule

bind xcorr_window xcorr_window_chk #(.DEPTH(ROWS*COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .clr(clr), .we(we)
);

// File: tb/tb_xcorr_window.sv
`timescale 1ns/1ps
module tb_xcorr_window;
  localparam int ROWS = 4, COLS = 4, SW = 8, AW = 16, DEPTH = ROWS * COLS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, done;
  logic [ROWS-1:0] bn, bo;
  logic [COLS*SW-1:0] rn, ro;
  logic [1:0] rr, rc;
  logic [AW-1:0] rd;

  xcorr_window #(.ROWS(ROWS), .COLS(COLS), .SW(SW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_new(bn), .bit_old(bo),
    .smp_new(rn), .smp_old(ro), .rd_row(rr), .rd_col(rc),
    .busy(busy), .done(done), .rd_data(rd));

  localparam logic [71:0] VEC [6] = '{
    {4'b1010, 4'b0110, 32'h05FB7F80, 32'h01020304},
    {4'b1111, 4'b0000, 32'h10203040, 32'hF0E0D0C0},
    {4'b0000, 4'b1111, 32'h817E0001, 32'h7F80FF02},
    {4'b1100, 4'b0011, 32'h12345678, 32'h9ABCDEF0},
    {4'b0101, 4'b1001, 32'hFFFFFFFF, 32'h01010101},
    {4'b0011, 4'b1110, 32'h44C422E2, 32'h33CC11EE}
  };

  int total = 0, bad = 0;
  logic [AW-1:0] em [ROWS][COLS];

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int term(logic b, logic [7:0] s);
    int v = int'($signed(s));
    return b ? v : -v;
  endfunction

  task automatic model(logic [3:0] b_n, logic [3:0] b_o, logic [31:0] r_n, logic [31:0] r_o);
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++)
        em[i][j] = em[i][j] + 16'(term(b_n[i], r_n[j*8 +: 8]) - term(b_o[i], r_o[j*8 +: 8]));
  endtask

  task automatic zero_model();
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) em[i][j] = '0;
  endtask

  task automatic check_matrix(string req);
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) begin
        @(negedge clk); rr = 2'(i); rc = 2'(j);
        @(negedge clk);
        chk(req, $sformatf("entry(%0d,%0d)", i, j), int'(rd), int'(em[i][j]));
      end
  endtask

  task automatic wait_clear(int exp_len);
    int cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (cnt == 5) begin start = 1'b1; bn = 4'hF; rn = 32'h11111111; end
      if (cnt == 6) start = 1'b0;
      @(negedge clk);
    end
    chk("R1", "clear length", cnt, exp_len);
    chk("R1", "no done after clear", int'(done), 0);
  endtask

  task automatic run_update(logic [3:0] b_n, logic [3:0] b_o, logic [31:0] r_n,
                            logic [31:0] r_o, bit noise, bit quiet);
    int cnt = 0;
    @(negedge clk);
    bn = b_n; bo = b_o; rn = r_n; ro = r_o; start = 1'b1;
    rr = 2'(ROWS-1); rc = 2'(COLS-1);
    @(negedge clk);
    start = 1'b0;
    model(b_n, b_o, r_n, r_o);
    if (!quiet) chk("R2", "busy after start", int'(busy), 1);
    if (noise) begin bn = ~b_n; bo = ~b_o; rn = r_n ^ 32'hA5A5A5A5; ro = ~r_o; end
    while (busy && cnt < 100) begin
      cnt++;
      if (noise && cnt == 3) start = 1'b1;
      if (noise && cnt == 4) start = 1'b0;
      @(negedge clk);
    end
    if (!quiet) begin
      chk(noise ? "R6" : "R5", "busy length", cnt, DEPTH + 1);
      chk("R5", "done pulse", int'(done), 1);
      chk("R8", "forwarded last entry", int'(rd), int'(em[ROWS-1][COLS-1]));
    end
    @(negedge clk);
    if (!quiet) begin
      chk("R5", "done single", int'(done), 0);
      chk("R6", "no restart", int'(busy), 0);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bn = '0; bo = '0; rn = '0; ro = '0; rr = '0; rc = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 1);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    wait_clear(DEPTH);
    zero_model();
    check_matrix("R1");

    for (int k = 0; k < 6; k++) begin
      run_update(VEC[k][71:68], VEC[k][67:64], VEC[k][63:32], VEC[k][31:0], k % 2 == 1, 1'b0);
      check_matrix((k % 2 == 1) ? "R2" : "R3");
    end

    @(negedge clk); rr = 2'd1; rc = 2'd2;
    @(negedge clk);
    chk("R7", "entry(1,2) latency", int'(rd), int'(em[1][2]));
    rr = 2'd2; rc = 2'd1;
    @(negedge clk);
    chk("R7", "entry(2,1) latency", int'(rd), int'(em[2][1]));

    for (int n = 0; n < 130; n++)
      run_update(4'hF, 4'hF, 32'h7F7F7F7F, 32'h80808080, 1'b0, 1'b1);
    check_matrix("R4");

    @(negedge clk);
    bn = 4'h3; bo = 4'h5; rn = 32'h01020304; ro = 32'h05060708; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_clear(DEPTH);
    zero_model();
    check_matrix("R1");

    summary();
    $finish;
  end
endmodule